// File: doc/BRIEF.md
# Thermometer-coded address match comparator

The block compares a 12-bit address bus against a 4-bit boundary code. The code does not name an address bit for bit; it names a split point. A code value n from 0 to 12 asks for the lowest n address lines to be low and every line above them to be high. When the bus fits that pattern the active-low flag `match_n` goes to 0. Codes 13 and 14 never match. Code 15 is treated like code 12, so it matches only an all-low bus. Address line 1 is `addr[0]` and line 12 is `addr[11]`.

The flag passes through a hold stage controlled by the level-sensitive enable `le`. While `le` is high the stage is transparent, so `match_n` follows the comparison in the same cycle. While `le` is low the flag is frozen, and changes on `code` or `addr` have no effect. The held value is taken at the clock edges where `le` is high. The inputs must therefore be stable across the last rising edge before `le` drops.

The hold stage is a three-state machine. EMPTY is the state after reset, where no value has been captured yet. TRACK is the state while `le` is high, where every edge captures the live result. FROZEN is the state after `le` goes low, where the captured value is presented. The transitions are as follows. EMPTY moves to TRACK on an edge with `le` high, and otherwise stays in EMPTY. TRACK moves to FROZEN on an edge with `le` low, and otherwise stays in TRACK. FROZEN moves to TRACK on an edge with `le` high, and otherwise stays in FROZEN. Reset returns the machine to EMPTY from any state.

Top module: `thermo_addr_match`

## Requirements
- R1: With `le` high and a code n in 0..12, `match_n` is 0 when `addr[n-1:0]` are all 0 and `addr[11:n]` are all 1.
- R2: With `le` high and a code in 0..12, any address other than the R1 pattern gives `match_n` = 1.
- R3: Code 0 matches only `addr` = 12'hFFF, and code 12 matches only `addr` = 12'h000.
- R4: Codes 13 and 14 give `match_n` = 1 for every address.
- R5: Code 15 gives `match_n` = 0 for `addr` = 12'h000 and 1 for every other address.
- R6: While `le` is high, `match_n` reflects the present `code` and `addr` in the same cycle, with no clock edge needed. This includes the cycle in which `le` rises again after a hold.
- R7: While `le` is low, `match_n` keeps the result captured at the last rising clock edge where `le` was high. Changes on `code` and `addr` are ignored.
- R8: With `rst_n` low, or after reset before any edge with `le` high, `match_n` is 1 while `le` is low. Reset also drops a previously held match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples `le` and captures the held result |
| rst_n | input | 1 | Asynchronous active-low reset |
| code | input | 4 | Boundary code: lines below the boundary must be low |
| addr | input | 12 | Address bus, `addr[0]` is line 1 |
| le | input | 1 | Enable: high is transparent, low holds |
| match_n | output | 1 | Active-low match flag |

## Verification
The bench goes after the codes at the edges of the range. A decoder that is off by one at the boundary would match the pattern of a neighbouring code, and the boundary sweep, which offers every code's neighbours, would show that as a wrong 0 or 1. The bench also covers codes 13 to 15. A design that let 13 or 14 through the mask would report a match for some pattern, and one that treated 15 as out of range would miss the all-low bus. For the hold, the bench drives matching and non-matching inputs while `le` is low. A leaky hold would let `match_n` follow them, and a hold stage that forgot reset would present a stale 0 after `rst_n`.

// File: rtl/thermo_match_pkg.sv
package thermo_match_pkg;

    // States of the hold stage on the match flag
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,   // after reset, nothing captured yet
        ST_TRACK  = 2'd1,   // enable high, capturing each edge
        ST_FROZEN = 2'd2    // enable low, presenting the captured flag
    } hold_state_e;

endpackage

// File: rtl/thermo_code_decode.sv
module thermo_code_decode #(
    parameter int ADDR_W = 12,
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] req_level,
    output logic              code_ok
);
    localparam logic [CODE_W-1:0] FULL_CODE = CODE_W'(ADDR_W);
    localparam logic [CODE_W-1:0] TOP_CODE  = {CODE_W{1'b1}};

    logic [CODE_W-1:0] boundary;

    // The all-ones code folds onto the full-width boundary
    always_comb begin
        if (code == TOP_CODE) begin
            boundary = FULL_CODE;
        end else begin
            boundary = code;
        end
        code_ok = (code <= FULL_CODE) || (code == TOP_CODE);
    end

    // Line i must be high when it sits at or above the boundary
    for (genvar i = 0; i < ADDR_W; i++) begin : g_level
        assign req_level[i] = (int'(boundary) <= i);
    end

endmodule

// File: rtl/addr_level_compare.sv
module addr_level_compare #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] req_level,
    input  logic              code_ok,
    output logic              live_n
);
    logic [ADDR_W-1:0] diff;
    logic              all_fit;

    always_comb begin
        diff    = addr ^ req_level;
        all_fit = ~|diff;
        live_n  = ~(all_fit & code_ok);
    end

endmodule

// File: rtl/match_hold_fsm.sv
module match_hold_fsm
    import thermo_match_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        le,
    input  logic        live_n,
    output logic        out_n,
    output hold_state_e state_o
);
    hold_state_e state_q;
    hold_state_e state_d;
    logic        held_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (le)  state_d = ST_TRACK;
            ST_TRACK:  if (!le) state_d = ST_FROZEN;
            ST_FROZEN: if (le)  state_d = ST_TRACK;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // Captured flag, loaded on every edge with enable high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b1;
        end else if (le) begin
            held_q <= live_n;
        end
    end

    // Output: transparent while enabled, otherwise per state
    always_comb begin
        out_n = 1'b1;
        if (le) begin
            out_n = live_n;
        end else begin
            unique case (state_q)
                ST_EMPTY:  out_n = 1'b1;
                ST_TRACK:  out_n = held_q;
                ST_FROZEN: out_n = held_q;
                default:   out_n = 1'b1;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/thermo_addr_match.sv
module thermo_addr_match
    import thermo_match_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [ADDR_W-1:0] addr,
    input  logic              le,
    output logic              match_n
);
    logic [ADDR_W-1:0] req_level;
    logic              code_ok;
    logic              live_n;
    hold_state_e       hold_state;

    thermo_code_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_decode (
        .code      (code),
        .req_level (req_level),
        .code_ok   (code_ok)
    );

    addr_level_compare #(.ADDR_W(ADDR_W)) u_compare (
        .addr      (addr),
        .req_level (req_level),
        .code_ok   (code_ok),
        .live_n    (live_n)
    );

    match_hold_fsm u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .le      (le),
        .live_n  (live_n),
        .out_n   (match_n),
        .state_o (hold_state)
    );

endmodule

// File: rtl/thermo_addr_match_chk.sv
module thermo_addr_match_chk
    import thermo_match_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code,
    input logic [ADDR_W-1:0] addr,
    input logic              le,
    input logic              match_n,
    input hold_state_e       hold_state
);
    localparam logic [CODE_W-1:0] FULL_CODE = CODE_W'(ADDR_W);
    localparam logic [CODE_W-1:0] TOP_CODE  = {CODE_W{1'b1}};

    // R1
    r1_low_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le && !match_n && code <= FULL_CODE) |->
            ($countones(addr) == ADDR_W - int'(code)));

    // R3
    r3_code0_all_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le && code == '0 && addr == {ADDR_W{1'b1}}) |-> !match_n);

    // R4
    r4_dead_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le && code > FULL_CODE && code != TOP_CODE) |-> match_n);

    // R5
    r5_top_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le && code == TOP_CODE) |-> (match_n == (addr != '0)));

    // R7
    r7_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> (le || $stable(match_n)));

    // R8
    r8_empty_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_state == ST_EMPTY && !le) |-> match_n);

endmodule

bind thermo_addr_match thermo_addr_match_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (code),
    .addr       (addr),
    .le         (le),
    .match_n    (match_n),
    .hold_state (hold_state)
);

// File: tb/thermo_addr_match_bench.sv
`timescale 1ns/1ps
module thermo_addr_match_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  code = '0;
    logic [11:0] addr = '0;
    logic        le = 1'b0;
    logic        match_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    thermo_addr_match u_thermo_addr_match (
        .clk(clk), .rst_n(rst_n), .code(code), .addr(addr), .le(le), .match_n(match_n)
    );

    always #10 clk = ~clk;   // 50 MHz

    // {code, addr, expected match_n}
    localparam logic [16:0] VEC [13] = '{
        {4'd0,  12'hFFF, 1'b0}, {4'd0,  12'hFFE, 1'b1},
        {4'd7,  12'hF80, 1'b0}, {4'd7,  12'hF00, 1'b1},
        {4'd7,  12'hFC0, 1'b1}, {4'd12, 12'h000, 1'b0},
        {4'd12, 12'h800, 1'b1}, {4'd13, 12'h000, 1'b1},
        {4'd14, 12'hC00, 1'b1}, {4'd15, 12'h000, 1'b0},
        {4'd15, 12'h001, 1'b1}, {4'd1,  12'hFFE, 1'b0},
        {4'd11, 12'h800, 1'b0}
    };

    function automatic logic ref_n(input logic [3:0] c, input logic [11:0] a);
        int n;
        logic [11:0] pat;
        if (c == 4'd13 || c == 4'd14) return 1'b1;
        n = (c == 4'd15) ? 12 : int'(c);
        pat = 12'hFFF << n;
        return (a != pat);
    endfunction

    function automatic string tag_of(input logic [3:0] c, input logic e);
        if (c == 4'd13 || c == 4'd14) return "R4";
        if (c == 4'd15) return "R5";
        if (c == 4'd0 || c == 4'd12) return "R3";
        return e ? "R2" : "R1";
    endfunction

    task automatic check(input string tag, input logic exp);
        checks++;
        if (match_n !== exp) begin
            fails++;
            $display("FAIL %s: match_n=%b expected %b (code=%0d addr=%h le=%b)",
                     tag, match_n, exp, code, addr, le);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [11:0] a);
        @(negedge clk);
        code = c;
        addr = a;
        #5;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            summary();
        end
    end

    initial begin
        // R8: reset with matching inputs and le low
        code = 4'd5; addr = 12'hFE0;
        #5;
        check("R8 during reset", 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R8 after reset", 1'b1);
        repeat (2) @(negedge clk);
        #5;
        check("R8 idle", 1'b1);

        // Table walk, transparent mode
        @(negedge clk);
        le = 1'b1;
        for (int i = 0; i < 13; i++) begin
            apply(VEC[i][16:13], VEC[i][12:1]);
            check(tag_of(VEC[i][16:13], VEC[i][0]), VEC[i][0]);
        end

        // Sweep every code against one-hot and boundary addresses
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 12; k++) begin
                apply(4'(c), 12'(1) << k);
                check(tag_of(4'(c), ref_n(4'(c), 12'(1) << k)), ref_n(4'(c), 12'(1) << k));
            end
            for (int n = 0; n <= 12; n++) begin
                apply(4'(c), 12'hFFF << n);
                check(tag_of(4'(c), ref_n(4'(c), 12'hFFF << n)), ref_n(4'(c), 12'hFFF << n));
            end
        end

        // R7: hold a match while inputs change
        apply(4'd5, 12'hFE0);
        check("R1 before hold", 1'b0);
        @(negedge clk);
        le = 1'b0;
        code = 4'd13;
        addr = 12'h123;
        #5;
        check("R7 hold match", 1'b0);
        for (int j = 0; j < 4; j++) begin
            apply(4'(j), 12'hFFF);
            check("R7 hold match vs changes", 1'b0);
        end

        // R6: reopen with a mismatching input, same cycle
        code = 4'd3; addr = 12'h0F0;
        #2;
        le = 1'b1;
        #1;
        check("R6 reopen transparent", 1'b1);
        apply(4'd3, 12'hFF8);
        check("R6 follows input", 1'b0);
        apply(4'd3, 12'hFF0);
        check("R6 follows input", 1'b1);

        // R7: hold a no-match while matching inputs arrive
        @(negedge clk);
        le = 1'b0;
        code = 4'd12;
        addr = 12'h000;
        #5;
        check("R7 hold no-match", 1'b1);
        apply(4'd15, 12'h000);
        check("R7 hold no-match", 1'b1);

        // R8: reset drops a held match
        @(negedge clk);
        le = 1'b1;
        code = 4'd0;
        addr = 12'hFFF;
        #5;
        check("R1 match before reset", 1'b0);
        @(negedge clk);
        le = 1'b0;
        #5;
        check("R7 held before reset", 1'b0);
        rst_n = 1'b0;
        #2;
        check("R8 reset clears hold", 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R8 empty after reset", 1'b1);

        summary();
    end

endmodule